// File: doc/BRIEF.md
# DMA Channel Request Arbiter with Shared Flag Register

This block decides which channel of a multi-channel DMA controller may move its next data item. Each channel collects several peripheral request lines, ORs them into one request and qualifies that request with the channel's enable. Each channel also has a 2-bit programmed level. Among all qualified requests, the arbiter picks the channel with the highest level. When several channels share that level, the lowest-numbered channel wins. The chosen channel keeps the grant until it reports that its current item is finished. The arbiter then chooses again.

The same block holds the controller's shared interrupt flag register. Every channel owns a 4-bit field in that register, made of three event flags and a summary flag. Flags are set by pulses from the channel datapaths. Software clears them through a separate write-one-to-clear port, and it can clear several flags, across several channels, in one write.

Top module: `dma_req_arbiter`

## Requirements
- R1: The request of channel c is the OR of input lines `periph_req[c*LINES_PER_CH +: LINES_PER_CH]`, ANDed with `ch_enable[c]`. A channel whose enable is low never receives a new grant, whatever its lines or level.
- R2: The level of channel c is `ch_level[2c+1:2c]`, where 0 is the lowest and 3 the highest. The qualified request with the highest level wins, regardless of channel number.
- R3: Among qualified requests at the same highest level, the lowest channel number wins.
- R4: The arbiter decides when no grant is held, when `item_done` is high, or when the granted channel's enable is low. The decision uses the inputs of that cycle and appears on the grant outputs after the next rising clock edge.
- R5: While a grant is held, and `item_done` is low and the granted channel stays enabled, the grant does not change, even if a higher-level request appears. Dropping the granted channel's enable ends its grant at the next edge, and the arbiter decides again in that same step.
- R6: `grant_valid` flags a held grant. `grant_ch` gives the channel index and `grant_onehot` has exactly that bit set. With no grant, `grant_ch` and `grant_onehot` are all zero.
- R7: Channel c owns status bits `4c+3:4c`, laid out as follows:
  - bit 4c: summary
  - bit 4c+1: transfer complete
  - bit 4c+2: half transfer
  - bit 4c+3: error

  An event pulse on `evt_tc[c]`, `evt_ht[c]` or `evt_err[c]` sets its flag at the next edge. The summary bit is the OR of the channel's three event flags.
- R8: When `clr_we` is high, each 1 in `clr_data` clears the status flag at the same position at the next edge. Positions written with 0 keep their value. One write may clear flags of several channels.
- R9: A 1 written at a channel's summary position clears all three of that channel's event flags.
- R10: An event pulse and a clear of the same flag in the same cycle leave the flag set.
- R11: After reset, no grant is held and every status bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_req | input | NUM_CH*LINES_PER_CH | Peripheral request lines, LINES_PER_CH per channel |
| ch_enable | input | NUM_CH | Channel enables |
| ch_level | input | 2*NUM_CH | Programmed level per channel, 2 bits each |
| item_done | input | 1 | Granted channel has finished its current item |
| evt_tc | input | NUM_CH | Transfer-complete event pulses |
| evt_ht | input | NUM_CH | Half-transfer event pulses |
| evt_err | input | NUM_CH | Error event pulses |
| clr_we | input | 1 | Write strobe of the clear register |
| clr_data | input | 4*NUM_CH | Write-one-to-clear data, same layout as status |
| grant_valid | output | 1 | A grant is held |
| grant_ch | output | CH_W | Index of the granted channel |
| grant_onehot | output | NUM_CH | One-hot form of the granted channel |
| status | output | 4*NUM_CH | Shared flag register |

## Verification
Every result of this block comes one register stage after its cause:
- A grant decision made in cycle t shows on the grant outputs after the edge that ends cycle t.
- An event pulse or clear write in cycle t shows in `status` after that same edge.

The bench drives all inputs on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. For the hold checks it keeps `item_done` low across several edges and samples after each one, so that a change in any of those edges would be seen.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int LVL_W  = 2;
    localparam int FLAG_W = 4;
    // bit positions inside one channel's status field
    localparam int F_SUM  = 0;
    localparam int F_TC   = 1;
    localparam int F_HT   = 2;
    localparam int F_ERR  = 3;
endpackage

// File: rtl/dma_req_merge.sv
module dma_req_merge #(
    parameter int NUM_CH       = 7,
    parameter int LINES_PER_CH = 4
) (
    input  logic [NUM_CH*LINES_PER_CH-1:0] periph_req,
    input  logic [NUM_CH-1:0]              ch_enable,
    output logic [NUM_CH-1:0]              eligible
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign eligible[c] = ch_enable[c] & (|periph_req[c*LINES_PER_CH +: LINES_PER_CH]);
    end
endmodule

// File: rtl/dma_prio_select.sv
module dma_prio_select
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0]       eligible,
    input  logic [NUM_CH*LVL_W-1:0] ch_level,
    output logic                    found,
    output logic [CH_W-1:0]         winner
);
    logic [LVL_W-1:0] best_lvl;

    // Ascending scan with strict compare: a higher level replaces the
    // current pick, an equal level keeps the lower channel number.
    always_comb begin
        found    = 1'b0;
        winner   = '0;
        best_lvl = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (eligible[c] && (!found || ch_level[c*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                winner   = CH_W'(c);
                best_lvl = ch_level[c*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        evt_tc,
    input  logic [NUM_CH-1:0]        evt_ht,
    input  logic [NUM_CH-1:0]        evt_err,
    input  logic                     clr_we,
    input  logic [NUM_CH*FLAG_W-1:0] clr_data,
    output logic [NUM_CH*FLAG_W-1:0] status
);
    typedef struct packed {
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] ht;
        logic [NUM_CH-1:0] err;
    } flags_t;

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        for (int c = 0; c < NUM_CH; c++) begin
            logic wipe;
            wipe = clr_we & clr_data[c*FLAG_W + F_SUM];
            // a set pulse overrides a clear in the same cycle
            flg_d.tc[c]  = evt_tc[c]  | (flg_q.tc[c]  & ~(wipe | (clr_we & clr_data[c*FLAG_W + F_TC])));
            flg_d.ht[c]  = evt_ht[c]  | (flg_q.ht[c]  & ~(wipe | (clr_we & clr_data[c*FLAG_W + F_HT])));
            flg_d.err[c] = evt_err[c] | (flg_q.err[c] & ~(wipe | (clr_we & clr_data[c*FLAG_W + F_ERR])));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_field
        assign status[c*FLAG_W + F_SUM] = flg_q.tc[c] | flg_q.ht[c] | flg_q.err[c];
        assign status[c*FLAG_W + F_TC]  = flg_q.tc[c];
        assign status[c*FLAG_W + F_HT]  = flg_q.ht[c];
        assign status[c*FLAG_W + F_ERR] = flg_q.err[c];
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH       = 7,
    parameter int LINES_PER_CH = 4,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH*LINES_PER_CH-1:0] periph_req,
    input  logic [NUM_CH-1:0]              ch_enable,
    input  logic [NUM_CH*LVL_W-1:0]        ch_level,
    input  logic                           item_done,
    input  logic [NUM_CH-1:0]              evt_tc,
    input  logic [NUM_CH-1:0]              evt_ht,
    input  logic [NUM_CH-1:0]              evt_err,
    input  logic                           clr_we,
    input  logic [NUM_CH*FLAG_W-1:0]       clr_data,
    output logic                           grant_valid,
    output logic [CH_W-1:0]                grant_ch,
    output logic [NUM_CH-1:0]              grant_onehot,
    output logic [NUM_CH*FLAG_W-1:0]       status
);
    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } gnt_t;

    gnt_t              gnt_d, gnt_q;
    logic [NUM_CH-1:0] eligible;
    logic              found;
    logic [CH_W-1:0]   winner;

    dma_req_merge #(.NUM_CH(NUM_CH), .LINES_PER_CH(LINES_PER_CH)) merge_i (
        .periph_req (periph_req),
        .ch_enable  (ch_enable),
        .eligible   (eligible)
    );

    dma_prio_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) select_i (
        .eligible (eligible),
        .ch_level (ch_level),
        .found    (found),
        .winner   (winner)
    );

    dma_flag_bank #(.NUM_CH(NUM_CH)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_tc   (evt_tc),
        .evt_ht   (evt_ht),
        .evt_err  (evt_err),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .status   (status)
    );

    always_comb begin
        logic rearb;
        rearb = !gnt_q.valid || item_done || !ch_enable[gnt_q.ch];
        gnt_d = gnt_q;
        if (rearb) begin
            gnt_d.valid = found;
            gnt_d.ch    = found ? winner : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gnt_q <= '0;
        else        gnt_q <= gnt_d;
    end

    assign grant_valid = gnt_q.valid;
    assign grant_ch    = gnt_q.ch;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_onehot
        assign grant_onehot[c] = gnt_q.valid && (gnt_q.ch == CH_W'(c));
    end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NUM_CH = 7,
    parameter int CH_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   ch_enable,
    input logic                item_done,
    input logic [NUM_CH-1:0]   evt_tc,
    input logic [NUM_CH-1:0]   evt_ht,
    input logic [NUM_CH-1:0]   evt_err,
    input logic                clr_we,
    input logic [NUM_CH*4-1:0] clr_data,
    input logic                grant_valid,
    input logic [CH_W-1:0]     grant_ch,
    input logic [NUM_CH-1:0]   grant_onehot,
    input logic [NUM_CH*4-1:0] status
);
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_onehot == '0 && grant_ch == '0));

    p_enabled_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($past(ch_enable) >> grant_ch) & NUM_CH'(1)) != '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !item_done && ch_enable[grant_ch]) |=> (grant_valid && $stable(grant_ch)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_tc[c] | evt_ht[c] | evt_err[c]) |=> status[4*c]);

        p_sum_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[4*c] && !(evt_tc[c] | evt_ht[c] | evt_err[c]))
            |=> (status[4*c +: 4] == 4'b0000));
    end
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_enable    (ch_enable),
    .item_done    (item_done),
    .evt_tc       (evt_tc),
    .evt_ht       (evt_ht),
    .evt_err      (evt_err),
    .clr_we       (clr_we),
    .clr_data     (clr_data),
    .grant_valid  (grant_valid),
    .grant_ch     (grant_ch),
    .grant_onehot (grant_onehot),
    .status       (status)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;
    localparam int NCH = 7;
    localparam int NL  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*NL-1:0] periph_req = '0;
    logic [NCH-1:0]    ch_enable = '0;
    logic [NCH*2-1:0]  ch_level = '0;
    logic              item_done = 1'b0;
    logic [NCH-1:0]    evt_tc = '0, evt_ht = '0, evt_err = '0;
    logic              clr_we = 1'b0;
    logic [NCH*4-1:0]  clr_data = '0;
    logic              grant_valid;
    logic [2:0]        grant_ch;
    logic [NCH-1:0]    grant_onehot;
    logic [NCH*4-1:0]  status;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NCH), .LINES_PER_CH(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ch_enable(ch_enable),
        .ch_level(ch_level), .item_done(item_done), .evt_tc(evt_tc), .evt_ht(evt_ht),
        .evt_err(evt_err), .clr_we(clr_we), .clr_data(clr_data),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .grant_onehot(grant_onehot),
        .status(status)
    );

    typedef struct packed {
        logic [27:0] req;
        logic [6:0]  en;
        logic [13:0] lvl;
        logic        v;
        logic [2:0]  ch;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{28'h0004000, 7'h7F, 14'h0000, 1'b1, 3'd3},  // R1 single line
        '{28'h0200010, 7'h7F, 14'h0000, 1'b1, 3'd1},  // R3 equal level
        '{28'h0200010, 7'h7F, 14'h0800, 1'b1, 3'd5},  // R2 higher level
        '{28'h4000801, 7'h7F, 14'h3031, 1'b1, 3'd2},  // R3 tie at top level
        '{28'h0080002, 7'h7E, 14'h0003, 1'b1, 3'd4},  // R1 disabled skipped
        '{28'h0000002, 7'h7E, 14'h0003, 1'b0, 3'd0},  // R1 only disabled
        '{28'hF000000, 7'h7F, 14'h0000, 1'b1, 3'd6},  // R1 all lines
        '{28'h0000018, 7'h7F, 14'h0005, 1'b1, 3'd0},  // R3 adjacent lines
        '{28'h1000001, 7'h7F, 14'h3002, 1'b1, 3'd6}   // R2 high index wins
    };

    task automatic check_grant(input logic v, input logic [2:0] ch, input string tag);
        logic [NCH-1:0] oh;
        oh = v ? NCH'(1) << ch : '0;
        n_run++;
        if (grant_valid !== v || grant_ch !== ch || grant_onehot !== oh) begin
            n_fail++;
            $display("FAIL %s: grant v=%0d ch=%0d oh=%h, expected v=%0d ch=%0d oh=%h",
                     tag, grant_valid, grant_ch, grant_onehot, v, ch, oh);
        end
    endtask

    task automatic check_status(input logic [NCH*4-1:0] exp, input string tag);
        n_run++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%h, expected %h", tag, status, exp);
        end
    endtask

    task automatic rearb(input logic [27:0] r, input logic [6:0] e, input logic [13:0] l);
        @(negedge clk);
        periph_req = r; ch_enable = e; ch_level = l; item_done = 1'b1;
        @(negedge clk);
        item_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_grant(1'b0, 3'd0, "R11 reset grant");
        check_status('0, "R11 reset status");

        foreach (VECS[i]) begin
            rearb(VECS[i].req, VECS[i].en, VECS[i].lvl);
            check_grant(VECS[i].v, VECS[i].ch, $sformatf("R4 vector %0d", i));
        end

        // R5: grant held while a higher-level request waits
        rearb(28'h0004000, 7'h7F, 14'h0000);
        check_grant(1'b1, 3'd3, "R4 start hold");
        periph_req = 28'h0104000; ch_level = 14'h0C00;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_grant(1'b1, 3'd3, "R5 hold against level 3");
        end
        item_done = 1'b1;
        @(negedge clk);
        item_done = 1'b0;
        check_grant(1'b1, 3'd5, "R5 release to higher level");
        ch_enable = 7'h5F;
        @(negedge clk);
        check_grant(1'b1, 3'd3, "R5 disable ends grant");
        rearb(28'h0000000, 7'h7F, 14'h0000);
        check_grant(1'b0, 3'd0, "R6 idle after requests drop");

        // flags
        @(negedge clk); evt_tc = 7'h04;
        @(negedge clk); evt_tc = '0;
        check_status(28'h0000300, "R7 complete ch2");
        evt_ht = 7'h04; evt_err = 7'h20;
        @(negedge clk); evt_ht = '0; evt_err = '0;
        check_status(28'h0900700, "R7 two channels");
        clr_we = 1'b1; clr_data = 28'h0000200;
        @(negedge clk); clr_we = 1'b0; clr_data = '0;
        check_status(28'h0900500, "R8 single clear");
        clr_we = 1'b1; clr_data = 28'h0000000;
        @(negedge clk); clr_we = 1'b0;
        check_status(28'h0900500, "R8 zero write ignored");
        clr_we = 1'b1; clr_data = 28'h0100400;
        @(negedge clk); clr_we = 1'b0; clr_data = '0;
        check_status(28'h0000000, "R9 summary wipe plus R8 multi");
        evt_tc = 7'h01; clr_we = 1'b1; clr_data = 28'h0000003;
        @(negedge clk); evt_tc = '0; clr_we = 1'b0; clr_data = '0;
        check_status(28'h0000003, "R10 set beats clear");
        clr_we = 1'b1; clr_data = 28'h0000001;
        @(negedge clk); clr_we = 1'b0; clr_data = '0;
        check_status(28'h0000000, "R9 summary wipe ch0");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule